// File: doc/BRIEF.md
# Byte ALU with Offset Arithmetic and Iterative Divide

This block is the arithmetic and logic engine of a small 8-bit controller core. Every operation is requested by a one-cycle `start` strobe, which carries an opcode and up to three operand bytes. It returns a result as a high byte and a low byte, a carry flag, a sign flag and a separate bit-test output. Most operations finish on the first clock edge. Divide runs iteratively, keeps `busy` high while it works, and marks its end with a one-cycle `done` pulse, the same strobe that every other operation produces.

The block has two add/subtract variants for signed bytes. These shift the result by 128, so that values biased into the range -128..127 can be handled as if they were unsigned bytes. Multiply returns a 16-bit product split across the two result bytes. Divide takes a 16-bit dividend as a high byte and a low byte. It returns the quotient in the high result byte and the remainder in the low result byte, so a caller can write both back over the pair of registers the dividend came from.

Top module: `smallAlu`

## Requirements
- R1: Opcode 0 (add) returns lo = (A+B) mod 256 and hi = 0, with carry = 1 when A+B > 255 and sign = 0. Opcode 1 (subtract) returns lo = (A-B) mod 256 and hi = 0, with sign = 1 when A < B and carry = 0.
- R2: Opcode 2 (offset add) computes t = A+B-128 and opcode 3 (offset subtract) computes t = A-B+128. Both return lo = t mod 256 and hi = 0, with carry = 1 exactly when t > 255 and sign = 1 exactly when t < 0.
- R3: Opcodes 4, 5 and 6 return A AND B, A OR B and A XOR B in lo, with hi = 0, and leave carry and sign unchanged.
- R4: The bit index is B[2:0], and the upper bits of B are ignored. Opcode 7 sets that bit of A and opcode 8 clears it, returning the result in lo. Opcode 9 copies that bit of A to bitTest and returns A in lo. All three give hi = 0 and leave carry and sign unchanged. bitTest changes only on opcode 9.
- R5: Opcode 10 shifts A left, filling with 0. Opcode 11 shifts A right, filling with 0. Opcode 12 rotates A left and opcode 13 rotates A right. Each returns the result in lo with hi = 0, and leaves the flags unchanged.
- R6: Opcode 14 returns the 16-bit product A*B, with the high byte in hi and the low byte in lo. It clears carry and sign.
- R7: Opcode 15 divides {A,B} by C. It returns the low 8 bits of the quotient in hi and the remainder in lo. Carry is set when the full quotient exceeds 255, and sign is cleared.
- R8: Opcode 15 with C = 0 returns hi = 0xFF and lo = B, sets carry and clears sign, and completes in one cycle.
- R9: Every operation except a divide by a nonzero C raises done in the cycle after its start edge. A divide by a nonzero C holds busy high for 8 cycles and raises done with its results 8 edges after the start edge. done is always a single-cycle pulse and is never high while busy is high.
- R10: A start that arrives while busy is high is ignored. It produces no extra done and does not alter the divide result.
- R11: After reset, hi, lo, carry, sign, bitTest, done and busy are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| opcode | input | 4 | Operation select |
| opA | input | 8 | Operand A, or the dividend high byte |
| opB | input | 8 | Operand B, the bit index, or the dividend low byte |
| opC | input | 8 | Divisor |
| resHi | output | 8 | Result high byte (product high byte or quotient) |
| resLo | output | 8 | Result low byte (product low byte or remainder) |
| carry | output | 1 | Overflow flag |
| sign | output | 1 | Underflow flag |
| bitTest | output | 1 | Value of the most recently tested bit |
| done | output | 1 | Completion pulse |
| busy | output | 1 | Divide in progress |

## Verification
The bench builds the block with its defaults: an 8-bit datapath and two restoring steps per clock, which gives an 8-cycle divide. With these values the quotients above 255, such as 0xFFFF/1 and 0x1234/0x10, can be reached. They exercise the truncation and carry rule, and a start strobe can be placed while busy is still high. The 3-bit index field also lets the bench pass B = 0x0F and show that the upper bits of B are discarded.

// File: rtl/smallAluPkg.sv
package smallAluPkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_ADDO = 4'd2,  OP_SUBO = 4'd3,
    OP_AND  = 4'd4,  OP_OR   = 4'd5,  OP_XOR  = 4'd6,  OP_BSET = 4'd7,
    OP_BCLR = 4'd8,  OP_BTST = 4'd9,  OP_SHL  = 4'd10, OP_SHR  = 4'd11,
    OP_ROL  = 4'd12, OP_ROR  = 4'd13, OP_MUL  = 4'd14, OP_DIV  = 4'd15
  } aluOp_e;

  typedef struct packed {
    logic execOne;   // single-cycle operation writes results now
    logic loadDiv;   // capture dividend and divisor
    logic stepDiv;   // advance the divider by one clock of steps
    logic finishDiv; // last divider clock: write quotient and remainder
  } aluStrobe_t;
endpackage

// File: rtl/smallAluCtrl.sv
module smallAluCtrl
  import smallAluPkg::*;
#(
  parameter int DIV_CYC = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] opcode,
  input  logic       divisorZero,
  output aluStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  localparam int CW = $clog2(DIV_CYC + 1);

  logic [CW-1:0] cnt;
  logic accept;
  logic isDiv;

  assign accept = start && !busy;
  assign isDiv  = (opcode == OP_DIV);

  always_comb begin
    strobe           = '0;
    strobe.execOne   = accept && !(isDiv && !divisorZero);
    strobe.loadDiv   = accept && isDiv && !divisorZero;
    strobe.stepDiv   = busy;
    strobe.finishDiv = busy && (cnt == CW'(DIV_CYC - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= strobe.execOne || strobe.finishDiv;
      if (strobe.loadDiv) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (strobe.finishDiv) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/smallAluPath.sv
module smallAluPath
  import smallAluPkg::*;
#(
  parameter int W     = 8,
  parameter int STEPS = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  aluStrobe_t   strobe,
  input  logic [3:0]   opcode,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] opC,
  output logic         divisorZero,
  output logic [W-1:0] resHi,
  output logic [W-1:0] resLo,
  output logic         carry,
  output logic         sign,
  output logic         bitTest
);
  localparam int IW  = $clog2(W);
  localparam int OFF = 1 << (W - 1);

  aluOp_e op;
  assign op = aluOp_e'(opcode);
  assign divisorZero = (opC == '0);

  // arithmetic: two guard bits, top bit = negative, next = overflow
  logic [W+1:0] arithVal;
  always_comb begin
    case (op)
      OP_ADD:  arithVal = {2'b00, opA} + {2'b00, opB};
      OP_SUB:  arithVal = {2'b00, opA} - {2'b00, opB};
      OP_ADDO: arithVal = {2'b00, opA} + {2'b00, opB} - (W+2)'(OFF);
      default: arithVal = {2'b00, opA} - {2'b00, opB} + (W+2)'(OFF);
    endcase
  end

  logic [IW-1:0] bitIdx;
  logic [W-1:0]  bitMask;
  logic [W-1:0]  simpleRes;
  assign bitIdx  = opB[IW-1:0];
  assign bitMask = W'(1) << bitIdx;

  always_comb begin
    case (op)
      OP_AND:  simpleRes = opA & opB;
      OP_OR:   simpleRes = opA | opB;
      OP_XOR:  simpleRes = opA ^ opB;
      OP_BSET: simpleRes = opA | bitMask;
      OP_BCLR: simpleRes = opA & ~bitMask;
      OP_SHL:  simpleRes = {opA[W-2:0], 1'b0};
      OP_SHR:  simpleRes = {1'b0, opA[W-1:1]};
      OP_ROL:  simpleRes = {opA[W-2:0], opA[W-1]};
      OP_ROR:  simpleRes = {opA[0], opA[W-1:1]};
      default: simpleRes = opA;
    endcase
  end

  logic [2*W-1:0] product;
  assign product = {{W{1'b0}}, opA} * {{W{1'b0}}, opB};

  // restoring divider, STEPS quotient bits per clock
  logic [W:0]     remQ;
  logic [2*W-1:0] quoQ;
  logic [W-1:0]   dvsQ;
  logic [W:0]     remS [0:STEPS];
  logic [2*W-1:0] quoS [0:STEPS];

  assign remS[0] = remQ;
  assign quoS[0] = quoQ;

  for (genvar s = 0; s < STEPS; s++) begin : gStep
    logic [W:0] shifted;
    logic [W:0] trial;
    assign shifted     = {remS[s][W-1:0], quoS[s][2*W-1]};
    assign trial       = shifted - {1'b0, dvsQ};
    assign remS[s+1]   = trial[W] ? shifted : trial;
    assign quoS[s+1]   = {quoS[s][2*W-2:0], ~trial[W]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remQ    <= '0;
      quoQ    <= '0;
      dvsQ    <= '0;
      resHi   <= '0;
      resLo   <= '0;
      carry   <= 1'b0;
      sign    <= 1'b0;
      bitTest <= 1'b0;
    end else begin
      if (strobe.loadDiv) begin
        remQ <= '0;
        quoQ <= {opA, opB};
        dvsQ <= opC;
      end else if (strobe.stepDiv) begin
        remQ <= remS[STEPS];
        quoQ <= quoS[STEPS];
      end

      if (strobe.finishDiv) begin
        resHi <= quoS[STEPS][W-1:0];
        resLo <= remS[STEPS][W-1:0];
        carry <= |quoS[STEPS][2*W-1:W];
        sign  <= 1'b0;
      end else if (strobe.execOne) begin
        case (op)
          OP_ADD, OP_SUB, OP_ADDO, OP_SUBO: begin
            resHi <= '0;
            resLo <= arithVal[W-1:0];
            sign  <= arithVal[W+1];
            carry <= !arithVal[W+1] && arithVal[W];
          end
          OP_MUL: begin
            {resHi, resLo} <= product;
            carry <= 1'b0;
            sign  <= 1'b0;
          end
          OP_DIV: begin
            resHi <= '1;
            resLo <= opB;
            carry <= 1'b1;
            sign  <= 1'b0;
          end
          OP_BTST: begin
            bitTest <= opA[bitIdx];
            resHi   <= '0;
            resLo   <= simpleRes;
          end
          default: begin
            resHi <= '0;
            resLo <= simpleRes;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/smallAlu.sv
module smallAlu
  import smallAluPkg::*;
#(
  parameter int W     = 8,
  parameter int STEPS = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [3:0]   opcode,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] opC,
  output logic [W-1:0] resHi,
  output logic [W-1:0] resLo,
  output logic         carry,
  output logic         sign,
  output logic         bitTest,
  output logic         done,
  output logic         busy
);
  localparam int DIV_CYC = (2 * W) / STEPS;

  aluStrobe_t strobe;
  logic       divisorZero;

  smallAluCtrl #(.DIV_CYC(DIV_CYC)) ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .divisorZero(divisorZero), .strobe(strobe), .busy(busy), .done(done)
  );

  smallAluPath #(.W(W), .STEPS(STEPS)) path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opcode(opcode),
    .opA(opA), .opB(opB), .opC(opC), .divisorZero(divisorZero),
    .resHi(resHi), .resLo(resLo), .carry(carry), .sign(sign),
    .bitTest(bitTest)
  );
endmodule

// File: rtl/smallAluChecker.sv
module smallAluChecker #(
  parameter int W     = 8,
  parameter int STEPS = 2
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic [3:0]   opcode,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic [W-1:0] resHi,
  input logic [W-1:0] resLo,
  input logic         carry,
  input logic         sign,
  input logic         done,
  input logic         busy
);
  localparam int DIV_CYC = (2 * W) / STEPS;

  logic [15:0] busyLen;
  always_ff @(posedge clk) begin
    if (!rstN) busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else busyLen <= '0;
  end

  logic accepted;
  logic isLogicOp;
  assign accepted  = start && !busy;
  assign isLogicOp = (opcode >= 4'd4) && (opcode <= 4'd13);

  a_r9_div_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyLen == 16'(DIV_CYC));

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r9_single_done: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && opcode != 4'd15) |=> done);

  a_r3_flags_kept: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && isLogicOp) |=> ($stable(carry) && $stable(sign)));

  a_r6_mul_product: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && opcode == 4'd14) |=>
      ({resHi, resLo} == (2*W)'($past(opA)) * (2*W)'($past(opB)) && !carry && !sign));

  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !(carry && sign));
endmodule

bind smallAlu smallAluChecker #(.W(W), .STEPS(STEPS)) chk (
  .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .opA(opA),
  .opB(opB), .resHi(resHi), .resLo(resLo), .carry(carry), .sign(sign),
  .done(done), .busy(busy)
);

// File: tb/smallAlu_test.sv
`timescale 1ns/1ps
module smallAlu_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [3:0] opcode = '0;
  logic [7:0] opA = '0, opB = '0, opC = '0;
  logic [7:0] resHi, resLo;
  logic       carry, sign, bitTest, done, busy;

  int total = 0;
  int bad = 0;

  localparam int DIV_LAT = 16 / 2 + 1;

  smallAlu uut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .opA(opA),
    .opB(opB), .opC(opC), .resHi(resHi), .resLo(resLo), .carry(carry),
    .sign(sign), .bitTest(bitTest), .done(done), .busy(busy)
  );

  always #10 clk = ~clk;

  // {op, A, B, C, expHi, expLo, expCarry, expSign, expBitTest}
  localparam int NV = 28;
  localparam logic [46:0] VEC [NV] = '{
    {4'd0,  8'h40, 8'h30, 8'h00, 8'h00, 8'h70, 1'b0, 1'b0, 1'b0},
    {4'd0,  8'hF0, 8'h20, 8'h00, 8'h00, 8'h10, 1'b1, 1'b0, 1'b0},
    {4'd4,  8'hF0, 8'h3C, 8'h00, 8'h00, 8'h30, 1'b1, 1'b0, 1'b0},
    {4'd1,  8'h10, 8'h20, 8'h00, 8'h00, 8'hF0, 1'b0, 1'b1, 1'b0},
    {4'd5,  8'h0F, 8'hA0, 8'h00, 8'h00, 8'hAF, 1'b0, 1'b1, 1'b0},
    {4'd6,  8'hFF, 8'h0F, 8'h00, 8'h00, 8'hF0, 1'b0, 1'b1, 1'b0},
    {4'd2,  8'h90, 8'h10, 8'h00, 8'h00, 8'h20, 1'b0, 1'b0, 1'b0},
    {4'd2,  8'h20, 8'h30, 8'h00, 8'h00, 8'hD0, 1'b0, 1'b1, 1'b0},
    {4'd2,  8'hF0, 8'hF0, 8'h00, 8'h00, 8'h60, 1'b1, 1'b0, 1'b0},
    {4'd3,  8'h10, 8'h20, 8'h00, 8'h00, 8'h70, 1'b0, 1'b0, 1'b0},
    {4'd3,  8'h00, 8'hFF, 8'h00, 8'h00, 8'h81, 1'b0, 1'b1, 1'b0},
    {4'd3,  8'hFF, 8'h00, 8'h00, 8'h00, 8'h7F, 1'b1, 1'b0, 1'b0},
    {4'd7,  8'h00, 8'h07, 8'h00, 8'h00, 8'h80, 1'b1, 1'b0, 1'b0},
    {4'd8,  8'hFF, 8'h03, 8'h00, 8'h00, 8'hF7, 1'b1, 1'b0, 1'b0},
    {4'd10, 8'h81, 8'h00, 8'h00, 8'h00, 8'h02, 1'b1, 1'b0, 1'b0},
    {4'd11, 8'h81, 8'h00, 8'h00, 8'h00, 8'h40, 1'b1, 1'b0, 1'b0},
    {4'd12, 8'h81, 8'h00, 8'h00, 8'h00, 8'h03, 1'b1, 1'b0, 1'b0},
    {4'd13, 8'h81, 8'h00, 8'h00, 8'h00, 8'hC0, 1'b1, 1'b0, 1'b0},
    {4'd14, 8'hFF, 8'hFF, 8'h00, 8'hFE, 8'h01, 1'b0, 1'b0, 1'b0},
    {4'd14, 8'h12, 8'h10, 8'h00, 8'h01, 8'h20, 1'b0, 1'b0, 1'b0},
    {4'd15, 8'h12, 8'h34, 8'h10, 8'h23, 8'h04, 1'b1, 1'b0, 1'b0},
    {4'd15, 8'h01, 8'h00, 8'h03, 8'h55, 8'h01, 1'b0, 1'b0, 1'b0},
    {4'd15, 8'h00, 8'hFF, 8'hFF, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0},
    {4'd15, 8'hFF, 8'hFF, 8'h01, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0},
    {4'd15, 8'h12, 8'h34, 8'h00, 8'hFF, 8'h34, 1'b1, 1'b0, 1'b0},
    {4'd1,  8'h05, 8'h05, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    {4'd9,  8'h20, 8'h05, 8'h00, 8'h00, 8'h20, 1'b0, 1'b0, 1'b1},
    {4'd7,  8'h00, 8'h0F, 8'h00, 8'h00, 8'h80, 1'b0, 1'b0, 1'b1}
  };

  function automatic string reqOf(input logic [3:0] op, input logic [7:0] c);
    if (op <= 4'd1) return "R1";
    if (op <= 4'd3) return "R2";
    if (op <= 4'd6) return "R3";
    if (op <= 4'd9) return "R4";
    if (op <= 4'd13) return "R5";
    if (op == 4'd14) return "R6";
    if (c == 8'h00) return "R8";
    return "R7";
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] c, output int lat);
    @(negedge clk);
    opcode = op; opA = a; opB = b; opC = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    int pulses;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", "resHi", resHi, 0);
    check("R11", "resLo", resLo, 0);
    check("R11", "flags", {carry, sign, bitTest, done, busy}, 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [46:0] v;
      string r;
      v = VEC[i];
      r = reqOf(v[46:43], v[26:19]);
      runOp(v[46:43], v[42:35], v[34:27], v[26:19], lat);
      check(r, "resHi", resHi, v[18:11]);
      check(r, "resLo", resLo, v[10:3]);
      check(r, "carry", carry, v[2]);
      check(r, "sign", sign, v[1]);
      if (v[46:43] == 4'd9) check("R4", "bitTest", bitTest, v[0]);
      if (v[46:43] == 4'd15 && v[26:19] != 8'h00) check("R9", "div latency", lat, DIV_LAT);
      else check(r == "R8" ? "R8" : "R9", "single latency", lat, 1);
    end

    // R4: test of a clear bit, flags kept
    runOp(4'd9, 8'h20, 8'h04, 8'h00, lat);
    check("R4", "bitTest clear", bitTest, 0);
    check("R4", "btst lo", resLo, 8'h20);
    // R4: bitTest unchanged by a non-test operation
    runOp(4'd9, 8'h01, 8'h08, 8'h00, lat);
    check("R4", "bitTest idx8->0", bitTest, 1);
    runOp(4'd0, 8'h00, 8'h00, 8'h00, lat);
    check("R4", "bitTest kept", bitTest, 1);

    // R9: done is a single pulse
    @(negedge clk);
    check("R9", "done pulse width", done, 0);

    // R9/R10: busy during divide, start while busy ignored
    @(negedge clk);
    opcode = 4'd15; opA = 8'h01; opB = 8'h00; opC = 8'h03; start = 1'b1;
    @(negedge clk);
    check("R9", "busy during divide", busy, 1);
    opcode = 4'd0; opA = 8'h01; opB = 8'h01; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pulses = 0;
    for (int k = 0; k < 16; k++) begin
      if (done) pulses++;
      if (done) begin
        check("R10", "div hi after stray start", resHi, 8'h55);
        check("R10", "div lo after stray start", resLo, 8'h01);
      end
      @(negedge clk);
    end
    check("R10", "done pulses", pulses, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule